// File: doc/BRIEF.md
# Pin Function Multiplexer and Output Latch Register File

This block holds the software-visible configuration of a bank of general-purpose pins. Each pin carries a 3-bit function code, which places it in one of three roles: a plain input, a plain output driven from its own output latch, or one of six alternate functions whose owner sits outside this block. Ten codes are packed into each 32-bit configuration word, so a pin's word and field position follow from its number.

Output data changes only through two write-only strobe registers per bank: one sets latch bits and one clears them. A bit written as 0 leaves its latch alone, so software never has to read, modify and write back the output state, and two agents can work on different pins of one bank without a lock. A read-only level register per bank returns the pin inputs after a short synchronizer.

Software reaches the block over a simple single-cycle register port: byte address, write strobe, write data, and read data that follows the address combinationally. Every read and write is one whole 32-bit word.

Top module: `pinmux_regfile`

## Requirements
- R1: After reset every function code is 0 (input), every output latch is 0, and `pin_oe`, `pin_alt_en` and `pin_out` are all 0.
- R2: Pin p's function code sits in the configuration word at byte offset 0x00 + 4*(p/10), in bits [3*(p%10)+2 : 3*(p%10)], and reads back as it was written.
- R3: Code 0 makes a pin an input (`pin_oe`=0, `pin_alt_en`=0); code 1 makes it an output (`pin_oe`=1, `pin_alt_en`=0). No pin ever has `pin_oe` and `pin_alt_en` high together.
- R4: Codes 4, 5, 6 and 7 raise `pin_alt_en` with alternate index 0, 1, 2 and 3 on `pin_alt_idx[3p+2:3p]`; code 3 gives index 4 and code 2 gives index 5. An alternate pin has `pin_oe`=0.
- R5: A write to the set register (0x1C for pins 0-31, 0x20 for pins 32-53; pin p is bit p%32) sets each latch whose bit is 1 and leaves the rest unchanged; `pin_out` shows the result from the next cycle. With no write, `pin_out` holds.
- R6: A write to the clear register (0x28 for pins 0-31, 0x2C for pins 32-53) clears each latch whose bit is 1 and leaves the rest unchanged.
- R7: The level register (0x34 for pins 0-31, 0x38 for pins 32-53; pin p at bit p%32) returns `pin_in` delayed by SYNC_STAGES clock cycles; bits 22 to 31 of the upper bank read 0.
- R8: Bits 30 and 31 of every configuration word, and the fields of the last word beyond pin 53 (bits 12 to 31 of 0x14), read 0 and ignore writes.
- R9: The set and clear registers read 0; an unmapped address (such as 0x18 or 0x30) reads 0, and writes to it or to a level register change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-assert active-low reset, sampled synchronously |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe; one word written per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 54 | Raw pin input levels |
| pin_oe | output | 54 | Output enable, high for pins with code 1 |
| pin_out | output | 54 | Output latch values |
| pin_alt_en | output | 54 | High for pins in an alternate function |
| pin_alt_idx | output | 162 | Alternate index 0..5 per pin, 3 bits per pin |

## Verification
The assertions assume that the register port carries at most one whole-word access per cycle, so a set and a clear of the same pin can never coincide and the later write always wins; they also assume addresses stay byte-aligned to words when they name a register. The stimulus writes one word per task call with a cycle between accesses, uses only aligned offsets, and changes `pin_in` only between clock edges, waiting out the synchronizer before reading the level registers.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

   localparam int FN_W      = 3;
   localparam int ALT_IDX_W = 3;

   typedef enum logic [FN_W-1:0] {
      FN_IN   = 3'd0,
      FN_OUT  = 3'd1,
      FN_ALT5 = 3'd2,
      FN_ALT4 = 3'd3,
      FN_ALT0 = 3'd4,
      FN_ALT1 = 3'd5,
      FN_ALT2 = 3'd6,
      FN_ALT3 = 3'd7
   } fn_code_e;

   typedef struct packed {
      logic                 oe;
      logic                 alt_en;
      logic [ALT_IDX_W-1:0] alt_idx;
   } pin_ctl_t;

   // Translate a stored code into pad-side controls.
   function automatic pin_ctl_t decode_fn(input logic [FN_W-1:0] code);
      pin_ctl_t c;
      c = '0;
      case (fn_code_e'(code))
         FN_IN:   c = '0;
         FN_OUT:  c.oe = 1'b1;
         FN_ALT0, FN_ALT1, FN_ALT2, FN_ALT3: begin
            c.alt_en  = 1'b1;
            c.alt_idx = {1'b0, code[1:0]};
         end
         FN_ALT4: begin
            c.alt_en  = 1'b1;
            c.alt_idx = 3'd4;
         end
         FN_ALT5: begin
            c.alt_en  = 1'b1;
            c.alt_idx = 3'd5;
         end
         default: c = '0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/pinmux_fsel.sv
module pinmux_fsel
   import pinmux_pkg::*;
#(
   parameter int NUM_PINS = 54,
   parameter int PER_WORD = 10,
   parameter int NWORDS   = 6,
   localparam int FS_W    = PER_WORD * FN_W,
   localparam int WIX_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [WIX_W-1:0]         wr_word,
   input  logic [FS_W-1:0]          wdata,
   input  logic [WIX_W-1:0]         rd_word,
   output logic [FS_W-1:0]          rdata,
   output logic [NUM_PINS*FN_W-1:0] fn_flat
);

   logic [NUM_PINS*FN_W-1:0] fn_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fn_q <= '0;
      end else if (wr_en) begin
         for (int p = 0; p < NUM_PINS; p++) begin
            if (int'(wr_word) == p / PER_WORD)
               fn_q[p*FN_W +: FN_W] <= wdata[(p % PER_WORD)*FN_W +: FN_W];
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int p = 0; p < NUM_PINS; p++) begin
         if (int'(rd_word) == p / PER_WORD)
            rdata[(p % PER_WORD)*FN_W +: FN_W] = fn_q[p*FN_W +: FN_W];
      end
   end

   assign fn_flat = fn_q;

endmodule

// File: rtl/pinmux_outlatch.sv
module pinmux_outlatch #(
   parameter int NUM_PINS = 54,
   parameter int DATA_W   = 32,
   parameter int NBANKS   = 2,
   localparam int BIX_W   = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_en,
   input  logic                clr_en,
   input  logic [BIX_W-1:0]    bank,
   input  logic [DATA_W-1:0]   wdata,
   output logic [NUM_PINS-1:0] out_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q <= '0;
      end else begin
         for (int p = 0; p < NUM_PINS; p++) begin
            if (int'(bank) == p / DATA_W && wdata[p % DATA_W]) begin
               if (set_en)      out_q[p] <= 1'b1;
               else if (clr_en) out_q[p] <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/pinmux_insync.sv
module pinmux_insync #(
   parameter int NUM_PINS = 54,
   parameter int STAGES   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] raw_in,
   output logic [NUM_PINS-1:0] sync_out
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign sync_out = raw_in;
      end else begin : g_chain
         logic [NUM_PINS-1:0] stage_q [STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= raw_in;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign sync_out = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pinmux_regfile.sv
module pinmux_regfile
   import pinmux_pkg::*;
#(
   parameter int NUM_PINS    = 54,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int FSEL_BASE   = 'h00,
   parameter int SET_BASE    = 'h1C,
   parameter int CLR_BASE    = 'h28,
   parameter int LEV_BASE    = 'h34
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic                          bus_wr,
   input  logic [DATA_W-1:0]             bus_wdata,
   output logic [DATA_W-1:0]             bus_rdata,
   input  logic [NUM_PINS-1:0]           pin_in,
   output logic [NUM_PINS-1:0]           pin_oe,
   output logic [NUM_PINS-1:0]           pin_out,
   output logic [NUM_PINS-1:0]           pin_alt_en,
   output logic [NUM_PINS*ALT_IDX_W-1:0] pin_alt_idx
);

   localparam int PER_WORD = DATA_W / FN_W;
   localparam int FS_W     = PER_WORD * FN_W;
   localparam int NWORDS   = (NUM_PINS + PER_WORD - 1) / PER_WORD;
   localparam int NBANKS   = (NUM_PINS + DATA_W - 1) / DATA_W;
   localparam int WIX_W    = (NWORDS > 1) ? $clog2(NWORDS) : 1;
   localparam int BIX_W    = (NBANKS > 1) ? $clog2(NBANKS) : 1;

   // Elaboration-time parameter checks.
   generate
      if (DATA_W != 32)
         $error("pinmux_regfile: DATA_W must be 32");
      if (NUM_PINS < 1 || NUM_PINS > 4 * DATA_W)
         $error("pinmux_regfile: NUM_PINS out of range");
      if (FSEL_BASE + 4 * NWORDS > SET_BASE)
         $error("pinmux_regfile: configuration words overlap the set registers");
      if (SET_BASE + 4 * NBANKS > CLR_BASE || CLR_BASE + 4 * NBANKS > LEV_BASE)
         $error("pinmux_regfile: strobe or level regions overlap");
      if (LEV_BASE + 4 * NBANKS > (1 << ADDR_W))
         $error("pinmux_regfile: address space too small");
   endgenerate

   // Address decode.
   int               addr_i;
   logic             aligned;
   logic             fs_hit, set_hit, clr_hit, lev_hit;
   logic [WIX_W-1:0] fs_word;
   logic [BIX_W-1:0] bank_sel;

   always_comb begin
      addr_i   = int'(bus_addr);
      aligned  = (bus_addr[1:0] == 2'b00);
      fs_hit   = aligned && addr_i >= FSEL_BASE && addr_i < FSEL_BASE + 4*NWORDS;
      set_hit  = aligned && addr_i >= SET_BASE  && addr_i < SET_BASE  + 4*NBANKS;
      clr_hit  = aligned && addr_i >= CLR_BASE  && addr_i < CLR_BASE  + 4*NBANKS;
      lev_hit  = aligned && addr_i >= LEV_BASE  && addr_i < LEV_BASE  + 4*NBANKS;
      fs_word  = WIX_W'((addr_i - FSEL_BASE) / 4);
      bank_sel = '0;
      if (set_hit) bank_sel = BIX_W'((addr_i - SET_BASE) / 4);
      if (clr_hit) bank_sel = BIX_W'((addr_i - CLR_BASE) / 4);
      if (lev_hit) bank_sel = BIX_W'((addr_i - LEV_BASE) / 4);
   end

   // Function-code storage.
   logic [FS_W-1:0]          fs_rdata;
   logic [NUM_PINS*FN_W-1:0] fn_flat;

   pinmux_fsel #(
      .NUM_PINS (NUM_PINS),
      .PER_WORD (PER_WORD),
      .NWORDS   (NWORDS)
   ) fsel_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr && fs_hit),
      .wr_word (fs_word),
      .wdata   (bus_wdata[FS_W-1:0]),
      .rd_word (fs_word),
      .rdata   (fs_rdata),
      .fn_flat (fn_flat)
   );

   // Output latches, touched only by set/clear strobes.
   pinmux_outlatch #(
      .NUM_PINS (NUM_PINS),
      .DATA_W   (DATA_W),
      .NBANKS   (NBANKS)
   ) latch_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (bus_wr && set_hit),
      .clr_en (bus_wr && clr_hit),
      .bank   (bank_sel),
      .wdata  (bus_wdata),
      .out_q  (pin_out)
   );

   // Input level sampling.
   logic [NUM_PINS-1:0]      lev_q;
   logic [NBANKS*DATA_W-1:0] lev_pad;

   pinmux_insync #(
      .NUM_PINS (NUM_PINS),
      .STAGES   (SYNC_STAGES)
   ) sync_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (pin_in),
      .sync_out (lev_q)
   );

   always_comb begin
      lev_pad                 = '0;
      lev_pad[NUM_PINS-1:0]   = lev_q;
   end

   // Read mux.
   always_comb begin
      bus_rdata = '0;
      if (fs_hit)
         bus_rdata[FS_W-1:0] = fs_rdata;
      else if (lev_hit)
         bus_rdata = lev_pad[int'(bank_sel)*DATA_W +: DATA_W];
   end

   // Per-pin pad controls.
   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         pin_ctl_t ctl;
         assign ctl = decode_fn(fn_flat[p*FN_W +: FN_W]);
         assign pin_oe[p]                              = ctl.oe;
         assign pin_alt_en[p]                          = ctl.alt_en;
         assign pin_alt_idx[p*ALT_IDX_W +: ALT_IDX_W] = ctl.alt_idx;
      end
   endgenerate

endmodule

// File: rtl/pinmux_regfile_chk.sv
module pinmux_regfile_chk #(
   parameter int NUM_PINS  = 54,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int FSEL_BASE = 'h00,
   parameter int SET_BASE  = 'h1C,
   parameter int CLR_BASE  = 'h28
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_wr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic [NUM_PINS-1:0] pin_alt_en,
   input logic [NUM_PINS-1:0] pin_out
);

   localparam int PER_WORD = DATA_W / 3;
   localparam int NWORDS   = (NUM_PINS + PER_WORD - 1) / PER_WORD;
   localparam int B0W      = (NUM_PINS < DATA_W) ? NUM_PINS : DATA_W;
   localparam logic [ADDR_W-1:0] SET_A   = ADDR_W'(SET_BASE);
   localparam logic [ADDR_W-1:0] CLR_A   = ADDR_W'(CLR_BASE);
   localparam logic [ADDR_W-1:0] FS_LO   = ADDR_W'(FSEL_BASE);
   localparam logic [ADDR_W-1:0] FS_HI   = ADDR_W'(FSEL_BASE + 4*NWORDS);

   // R3: output enable and alternate select never both high on a pin
   a_r3_oe_alt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & pin_alt_en) == '0);

   // R5: a set strobe only raises bits of the lower bank
   a_r5_set_bank0: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == SET_A) |=>
         pin_out[B0W-1:0] == ($past(pin_out[B0W-1:0]) | $past(bus_wdata[B0W-1:0])));

   // R5: latches hold when nothing is written
   a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(pin_out));

   // R6: a clear strobe only lowers bits of the lower bank
   a_r6_clr_bank0: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == CLR_A) |=>
         pin_out[B0W-1:0] == ($past(pin_out[B0W-1:0]) & ~$past(bus_wdata[B0W-1:0])));

   // R9: strobe registers read as zero
   a_r9_strobe_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == SET_A || bus_addr == CLR_A) |-> bus_rdata == '0);

   // R8: spare top bits of configuration words read zero
   a_r8_fsel_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr >= FS_LO && bus_addr < FS_HI && bus_addr[1:0] == 2'b00) |->
         (bus_rdata >> (PER_WORD*3)) == '0);

endmodule

bind pinmux_regfile pinmux_regfile_chk #(
   .NUM_PINS  (NUM_PINS),
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .FSEL_BASE (FSEL_BASE),
   .SET_BASE  (SET_BASE),
   .CLR_BASE  (CLR_BASE)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wr     (bus_wr),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .pin_oe     (pin_oe),
   .pin_alt_en (pin_alt_en),
   .pin_out    (pin_out)
);

// File: tb/pinmux_regfile_tb.sv
`timescale 1ns/1ps
module pinmux_regfile_tb_top;

   localparam int NP = 54;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_oe, pin_out, pin_alt_en;
   logic [NP*3-1:0] pin_alt_idx;

   always #10 clk = ~clk;

   pinmux_regfile dut_i (
      .clk (clk), .rst_n (rst_n),
      .bus_addr (bus_addr), .bus_wr (bus_wr), .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata), .pin_in (pin_in),
      .pin_oe (pin_oe), .pin_out (pin_out),
      .pin_alt_en (pin_alt_en), .pin_alt_idx (pin_alt_idx)
   );

   // kind: 0 read data, 1 pin_oe, 2 pin_out, 3 pin_alt_en, 4 alt index of one pin
   typedef struct {
      int          kind;
      int          pin;
      logic [63:0] exp;
      string       req;
   } item_t;

   item_t sb[$];
   logic  chk_valid = 1'b0;
   int    n_vec = 0;
   int    n_bad = 0;
   bit    done = 1'b0;

   // Monitor: pops one expected item per check strobe, away from the rising edge.
   always @(negedge clk) begin
      item_t       it;
      logic [63:0] act;
      if (chk_valid && sb.size() > 0) begin
         it  = sb.pop_front();
         act = '0;
         case (it.kind)
            0: act = 64'(bus_rdata);
            1: act = 64'(pin_oe);
            2: act = 64'(pin_out);
            3: act = 64'(pin_alt_en);
            default: act = 64'(pin_alt_idx[it.pin*3 +: 3]);
         endcase
         n_vec++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s kind %0d pin %0d: actual %h expected %h",
                     it.req, it.kind, it.pin, act, it.exp);
         end
      end
   end

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic expect_val(input int kind, input int pin, input logic [7:0] a,
                             input logic [63:0] exp, input string req);
      item_t it;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_addr = a;
      it.kind = kind; it.pin = pin; it.exp = exp; it.req = req;
      sb.push_back(it);
      chk_valid = 1'b1;
      @(negedge clk); #1;
      chk_valid = 1'b0;
   endtask

   // Alternate index expected for a function code, -1 when not alternate.
   function automatic int alt_of(input int code);
      case (code)
         4: return 0;
         5: return 1;
         6: return 2;
         7: return 3;
         3: return 4;
         2: return 5;
         default: return -1;
      endcase
   endfunction

   localparam logic [63:0] PMASK = (64'd1 << NP) - 64'd1;

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      int          codes [10];
      logic [31:0] w1;
      logic [63:0] exp_oe, exp_alt, exp_out;
      logic [NP-1:0] lvl;

      codes = '{0, 1, 2, 3, 4, 5, 6, 7, 1, 0};
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      expect_val(0, 0, 8'h00, 64'h0, "R1 word0");
      expect_val(0, 0, 8'h14, 64'h0, "R1 word5");
      expect_val(1, 0, 8'h00, 64'h0, "R1 oe");
      expect_val(2, 0, 8'h00, 64'h0, "R1 out");
      expect_val(3, 0, 8'h00, 64'h0, "R1 alt_en");

      // R8 spare bits of a full word; R4 code 7 on pins 0..9
      bus_write(8'h00, 32'hFFFF_FFFF);
      expect_val(0, 0, 8'h00, 64'h3FFF_FFFF, "R8 word0 spare bits");
      expect_val(3, 0, 8'h00, 64'h3FF, "R4 code7 alt_en");
      expect_val(4, 3, 8'h00, 64'd3, "R4 code7 idx");
      expect_val(1, 0, 8'h00, 64'h0, "R4 alt no oe");
      bus_write(8'h14, 32'hFFFF_FFFF);
      expect_val(0, 0, 8'h14, 64'hFFF, "R8 last word beyond pin 53");
      bus_write(8'h00, 32'h0);
      bus_write(8'h14, 32'h0);
      expect_val(3, 0, 8'h00, 64'h0, "R3 code0 input");

      // R2 field placement, R3 and R4 decoding on pins 10..19
      w1 = '0; exp_oe = '0; exp_alt = '0;
      for (int k = 0; k < 10; k++) begin
         w1 |= 32'(codes[k]) << (3 * k);
         if (codes[k] == 1) exp_oe |= 64'd1 << (10 + k);
         if (alt_of(codes[k]) >= 0) exp_alt |= 64'd1 << (10 + k);
      end
      bus_write(8'h04, w1);
      expect_val(0, 0, 8'h04, 64'(w1), "R2 word1 readback");
      expect_val(1, 0, 8'h00, exp_oe, "R3 output pins");
      expect_val(3, 0, 8'h00, exp_alt, "R4 alternate pins");
      for (int k = 2; k < 8; k++)
         expect_val(4, 10 + k, 8'h00, 64'(alt_of(codes[k])), "R4 index map");

      // R5 set strobes, R9 readback
      exp_out = '0;
      bus_write(8'h1C, 32'h0000_00F0);
      exp_out |= 64'hF0;
      expect_val(2, 0, 8'h00, exp_out, "R5 set bank0");
      bus_write(8'h20, 32'h8020_0001);
      exp_out = (exp_out | (64'h8020_0001 << 32)) & PMASK;
      expect_val(2, 0, 8'h00, exp_out, "R5 set bank1 pins 32 and 53");
      expect_val(0, 0, 8'h1C, 64'h0, "R9 set reads zero");
      expect_val(0, 0, 8'h2C, 64'h0, "R9 clear reads zero");
      bus_write(8'h1C, 32'h0);
      expect_val(2, 0, 8'h00, exp_out, "R5 zero bits no effect");

      // R6 clear strobes
      bus_write(8'h28, 32'h0000_0030);
      exp_out &= ~64'h30;
      expect_val(2, 0, 8'h00, exp_out, "R6 clear bank0");
      bus_write(8'h28, 32'h0);
      expect_val(2, 0, 8'h00, exp_out, "R6 zero bits no effect");
      bus_write(8'h2C, 32'hFFFF_FFFF);
      exp_out &= 64'hFFFF_FFFF;
      expect_val(2, 0, 8'h00, exp_out, "R6 clear bank1");

      // R9 unmapped and read-only addresses
      bus_write(8'h18, 32'hFFFF_FFFF);
      bus_write(8'h30, 32'hFFFF_FFFF);
      bus_write(8'h34, 32'hFFFF_FFFF);
      expect_val(0, 0, 8'h18, 64'h0, "R9 unmapped reads zero");
      expect_val(2, 0, 8'h00, exp_out, "R9 writes ignored out");
      expect_val(0, 0, 8'h04, 64'(w1), "R9 writes ignored fsel");

      // R7 input level through the synchronizer
      lvl = 54'h2A_5A5A_C3C3_F00F;
      @(negedge clk); pin_in = lvl;
      repeat (3) @(posedge clk);
      expect_val(0, 0, 8'h34, 64'(lvl[31:0]), "R7 level bank0");
      expect_val(0, 0, 8'h38, 64'(lvl[NP-1:32]), "R7 level bank1");
      @(negedge clk); pin_in = ~lvl;
      repeat (3) @(posedge clk);
      expect_val(0, 0, 8'h38, 64'(~lvl[NP-1:32]) & 64'h3F_FFFF, "R7 bank1 spare zero");

      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule